// File: doc/BRIEF.md
# Capture Input Noise Filter and Source Selector

This block conditions one capture input of a timer channel. It samples the raw input on one of three sample rates and moves its filtered level only after a programmed number of successive samples agree on a new level. A single 4-bit filter code chooses both the sample rate and the required run length. A derived base sampling clock, set by a 2-bit divider input, feeds the two slower rates.

A 2-bit channel mode register then decides what drives the channel's capture signal. The choices are this channel's filtered level, the neighbouring channel's filtered level, or an internal trigger. A fourth setting marks the channel as an output, and the capture signal is then held low. The mode register accepts writes only while the channel is disabled.

Top module: `cap_in_filter`

## Requirements
- R1: After reset is released, `filt_o` is 0, `mode_o` is 00, `is_output_o` is 1 and `cap_o` is 0.
- R2: With filter code 0000, `filt_o` equals the value `raw_i` had at the previous rising clock edge.
- R3: Filter codes 0001, 0010 and 0011 sample on every clock edge and need runs of 2, 4 and 8 equal samples.
- R4: Filter codes 0100 and 0101 sample at half the base rate and need runs of 6 and 8 equal samples.
- R5: Filter codes 0110 and 0111 sample at a quarter of the base rate and need runs of 6 and 8 equal samples.
- R6: Filter codes 1000 to 1111 behave like 0111: a quarter of the base rate with runs of 8.
- R7: `dts_div_i` sets the base period D in clock cycles: 00 gives 1, 01 gives 2, and 10 or 11 give 4. The edges after reset release are counted from 0. A sample at period P (1, 2D or 4D) is taken at edge n when n mod P equals P-1.
- R8: A sample that differs from the candidate level restarts the run at one. `filt_o` keeps its value until a full run of the new level completes.
- R9: The mode encoding is as follows. 00 makes the channel an output, so `is_output_o`=1 and `cap_o`=0. 01 drives `cap_o` from `filt_o`. 10 drives it from `nbr_filt_i`. 11 drives it from `trig_i`.
- R10: A pulse on `mode_wr_i` loads `mode_wdata_i` at the next edge only when `chan_en_i` is 0. While `chan_en_i` is 1, the write is ignored.
- R11: In mode 11, `cap_o` stays 0 while `trig_sel_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dts_div_i | input | 2 | Base sampling clock divider |
| flt_code_i | input | 4 | Filter rate and run-length code |
| mode_wr_i | input | 1 | Mode register write strobe |
| mode_wdata_i | input | 2 | Mode value to write |
| chan_en_i | input | 1 | Channel enable; locks the mode register |
| raw_i | input | 1 | Raw capture input, synchronous to clk_i |
| nbr_filt_i | input | 1 | Filtered level of the neighbouring channel |
| trig_sel_i | input | 1 | An internal trigger source is chosen |
| trig_i | input | 1 | Internal trigger signal |
| filt_o | output | 1 | Filtered level |
| cap_o | output | 1 | Selected capture signal |
| mode_o | output | 2 | Current mode register value |
| is_output_o | output | 1 | Channel is set up as an output |

## Verification
The bench builds the block with its default parameters: a longest run of 8 and two divided sample rates. With these values the longest accepted pulse spans 128 cycles, which is short enough to sweep every divider setting against every filter code class, including the out-of-range codes. Random hold lengths are scaled to each sample period. This places input changes just before, at and after run completion, and shows both restarts and acceptances.

// File: rtl/cf_pkg.sv
package cf_pkg;
  localparam int unsigned RUN_W = 4;

  typedef enum logic [1:0] {
    SRC_OUT = 2'b00,
    SRC_OWN = 2'b01,
    SRC_NBR = 2'b10,
    SRC_TRG = 2'b11
  } src_mode_e;

  typedef enum logic [1:0] {
    RATE_TCK = 2'd0,
    RATE_D2  = 2'd1,
    RATE_D4  = 2'd2
  } rate_e;

  typedef struct packed {
    logic             bypass;
    rate_e            rate;
    logic [RUN_W-1:0] len;
  } flt_cfg_t;

  function automatic flt_cfg_t decode_code(input logic [3:0] code);
    flt_cfg_t c;
    c.bypass = 1'b0;
    c.rate   = RATE_D4;
    c.len    = RUN_W'(8);
    unique case (code)
      4'd0: begin c.bypass = 1'b1; c.rate = RATE_TCK; c.len = RUN_W'(1); end
      4'd1: begin c.rate = RATE_TCK; c.len = RUN_W'(2); end
      4'd2: begin c.rate = RATE_TCK; c.len = RUN_W'(4); end
      4'd3: begin c.rate = RATE_TCK; c.len = RUN_W'(8); end
      4'd4: begin c.rate = RATE_D2;  c.len = RUN_W'(6); end
      4'd5: begin c.rate = RATE_D2;  c.len = RUN_W'(8); end
      4'd6: begin c.rate = RATE_D4;  c.len = RUN_W'(6); end
      default: begin c.rate = RATE_D4; c.len = RUN_W'(8); end
    endcase
    return c;
  endfunction
endpackage

// File: rtl/cf_strobe_gen.sv
module cf_strobe_gen #(
  parameter int unsigned DIV_W = 2,
  parameter int unsigned LVLS  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] dts_div_i,
  output logic [LVLS:0]    stb_o
);
  localparam int unsigned CNT_W = 2;

  logic [CNT_W-1:0] dts_cnt_q, dts_lim;
  logic [LVLS-1:0]  sub_cnt_q;
  logic             dts_stb;

  always_comb begin
    unique case (dts_div_i)
      2'b00:   dts_lim = CNT_W'(0);
      2'b01:   dts_lim = CNT_W'(1);
      default: dts_lim = CNT_W'(3);
    endcase
  end

  assign dts_stb = (dts_cnt_q == dts_lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dts_cnt_q <= '0;
      sub_cnt_q <= '0;
    end else if (dts_stb) begin
      dts_cnt_q <= '0;
      sub_cnt_q <= sub_cnt_q + 1'b1;
    end else begin
      dts_cnt_q <= dts_cnt_q + 1'b1;
    end
  end

  // level 0: every timer clock; level i: every 2^i base strobes
  assign stb_o[0] = 1'b1;
  for (genvar i = 1; i <= LVLS; i++) begin : g_lvl
    assign stb_o[i] = dts_stb & (&sub_cnt_q[i-1:0]);
  end

  // R7
  stb_nest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o[2] |-> stb_o[1]);
  // R4
  d2_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o[1] |=> !stb_o[1]);
endmodule

// File: rtl/cf_run_filter.sv
module cf_run_filter #(
  parameter int unsigned RUN_W   = 4,
  parameter int unsigned MAX_RUN = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stb_i,
  input  logic             bypass_i,
  input  logic [RUN_W-1:0] len_i,
  input  logic             raw_i,
  output logic             filt_o
);
  logic             filt_q, cand_q;
  logic [RUN_W-1:0] cnt_q, cnt_inc;

  assign cnt_inc = cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_q <= 1'b0;
      cand_q <= 1'b0;
      cnt_q  <= '0;
    end else if (bypass_i) begin
      filt_q <= raw_i;
      cand_q <= raw_i;
      cnt_q  <= '0;
    end else if (stb_i) begin
      if (raw_i != cand_q) begin
        cand_q <= raw_i;
        cnt_q  <= RUN_W'(1);
      end else if (cnt_q < len_i) begin
        cnt_q <= cnt_inc;
        if (cnt_inc == len_i) filt_q <= cand_q;
      end
    end
  end

  assign filt_o = filt_q;

  // R8
  filt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(stb_i) && !$past(bypass_i)) |-> $stable(filt_q));
  // R8
  run_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(bypass_i) && (filt_q != $past(filt_q))) |-> (cnt_q == $past(len_i)));
  // R3
  run_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= RUN_W'(MAX_RUN));
endmodule

// File: rtl/cf_src_sel.sv
module cf_src_sel (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mode_wr_i,
  input  logic [1:0] mode_wdata_i,
  input  logic       chan_en_i,
  input  logic       own_i,
  input  logic       nbr_i,
  input  logic       trig_sel_i,
  input  logic       trig_i,
  output logic       cap_o,
  output logic [1:0] mode_o
);
  import cf_pkg::*;

  src_mode_e mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      mode_q <= SRC_OUT;
    else if (mode_wr_i && !chan_en_i) mode_q <= src_mode_e'(mode_wdata_i);
  end

  always_comb begin
    unique case (mode_q)
      SRC_OWN: cap_o = own_i;
      SRC_NBR: cap_o = nbr_i;
      SRC_TRG: cap_o = trig_sel_i & trig_i;
      default: cap_o = 1'b0;
    endcase
  end

  assign mode_o = mode_q;

  // R10
  mode_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(chan_en_i) |-> $stable(mode_q));
  // R11
  trig_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == SRC_TRG && !trig_sel_i) |-> !cap_o);
  // R9
  out_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == SRC_OUT) |-> !cap_o);
endmodule

// File: rtl/cap_in_filter.sv
module cap_in_filter #(
  parameter int unsigned DIV_W   = 2,
  parameter int unsigned CODE_W  = 4,
  parameter int unsigned LVLS    = 2,
  parameter int unsigned MAX_RUN = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  dts_div_i,
  input  logic [CODE_W-1:0] flt_code_i,
  input  logic              mode_wr_i,
  input  logic [1:0]        mode_wdata_i,
  input  logic              chan_en_i,
  input  logic              raw_i,
  input  logic              nbr_filt_i,
  input  logic              trig_sel_i,
  input  logic              trig_i,
  output logic              filt_o,
  output logic              cap_o,
  output logic [1:0]        mode_o,
  output logic              is_output_o
);
  import cf_pkg::*;

  flt_cfg_t    cfg;
  logic [LVLS:0] stb_vec;
  logic        stb_sel;

  assign cfg = decode_code(flt_code_i);

  cf_strobe_gen #(.DIV_W(DIV_W), .LVLS(LVLS)) u_stb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dts_div_i (dts_div_i),
    .stb_o     (stb_vec)
  );

  always_comb begin
    unique case (cfg.rate)
      RATE_D2: stb_sel = stb_vec[1];
      RATE_D4: stb_sel = stb_vec[2];
      default: stb_sel = stb_vec[0];
    endcase
  end

  cf_run_filter #(.RUN_W(RUN_W), .MAX_RUN(MAX_RUN)) u_flt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .stb_i    (stb_sel),
    .bypass_i (cfg.bypass),
    .len_i    (cfg.len),
    .raw_i    (raw_i),
    .filt_o   (filt_o)
  );

  cf_src_sel u_src (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode_wr_i    (mode_wr_i),
    .mode_wdata_i (mode_wdata_i),
    .chan_en_i    (chan_en_i),
    .own_i        (filt_o),
    .nbr_i        (nbr_filt_i),
    .trig_sel_i   (trig_sel_i),
    .trig_i       (trig_i),
    .cap_o        (cap_o),
    .mode_o       (mode_o)
  );

  assign is_output_o = (mode_o == 2'b00);
endmodule

// File: tb/cap_in_filter_tb.sv
`timescale 1ns/1ps
module cap_in_filter_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] div = 2'd0;
  logic [3:0] code = 4'd0;
  logic mode_wr = 1'b0, chan_en = 1'b0, raw = 1'b0, nbr = 1'b0;
  logic trig_sel = 1'b0, trig = 1'b0;
  logic [1:0] mode_wd = 2'd0;
  logic filt, cap, is_out;
  logic [1:0] mode;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cap_in_filter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .dts_div_i(div), .flt_code_i(code),
    .mode_wr_i(mode_wr), .mode_wdata_i(mode_wd), .chan_en_i(chan_en),
    .raw_i(raw), .nbr_filt_i(nbr), .trig_sel_i(trig_sel), .trig_i(trig),
    .filt_o(filt), .cap_o(cap), .mode_o(mode), .is_output_o(is_out)
  );

  function automatic int base_d(input logic [1:0] d);
    return (d == 2'd0) ? 1 : (d == 2'd1) ? 2 : 4;
  endfunction
  function automatic int period(input logic [3:0] c, input logic [1:0] d);
    if (c <= 4'd3) return 1;
    if (c <= 4'd5) return 2 * base_d(d);
    return 4 * base_d(d);
  endfunction
  function automatic int run_len(input logic [3:0] c);
    case (c)
      4'd0: return 1; 4'd1: return 2; 4'd2: return 4;
      4'd4, 4'd6: return 6;
      default: return 8;
    endcase
  endfunction
  function automatic string req_of(input logic [3:0] c);
    if (c == 4'd0) return "R2";
    if (c <= 4'd3) return "R3/R7";
    if (c <= 4'd5) return "R4/R7";
    if (c <= 4'd7) return "R5/R7";
    return "R6/R7";
  endfunction

  // behavioural reference of the filtered level
  int cyc; logic m_filt, m_cand; int m_cnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc = 0; m_filt = 1'b0; m_cand = 1'b0; m_cnt = 0;
    end else begin
      if (code == 4'd0) m_filt = raw;
      else if (cyc % period(code, div) == period(code, div) - 1) begin
        if (raw != m_cand) begin m_cand = raw; m_cnt = 1; end
        else if (m_cnt < run_len(code)) begin
          m_cnt++;
          if (m_cnt == run_len(code)) m_filt = m_cand;
        end
      end
      cyc++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic [3:0] c, input logic [1:0] d);
    @(negedge clk); rst_n = 1'b0; raw = 1'b0; mode_wr = 1'b0; chan_en = 1'b0;
    code = c; div = d;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic write_mode(input logic [1:0] v);
    mode_wd = v; mode_wr = 1'b1;
    @(negedge clk); mode_wr = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1357));
    // R1 reset state
    do_reset(4'd0, 2'd0);
    chk("R1 filt", filt, 0); chk("R1 mode", mode, 0);
    chk("R1 is_out", is_out, 1); chk("R1 cap", cap, 0);

    // R9 routing, R11 trigger gating, R10 lock
    nbr = 1'b1; trig = 1'b1; trig_sel = 1'b1; raw = 1'b1;
    @(negedge clk);
    chk("R9 output cap", cap, 0);
    write_mode(2'b01); chk("R9 own", cap, filt); chk("R9 own mode", mode, 1);
    chk("R9 is_out", is_out, 0);
    write_mode(2'b10); chk("R9 nbr hi", cap, 1);
    nbr = 1'b0; #1 chk("R9 nbr lo", cap, 0);
    write_mode(2'b11); chk("R9 trig", cap, 1);
    trig_sel = 1'b0; #1 chk("R11 no trig source", cap, 0);
    trig_sel = 1'b1; trig = 1'b0; #1 chk("R9 trig lo", cap, 0);
    chan_en = 1'b1; write_mode(2'b00);
    chk("R10 locked mode", mode, 3); chk("R10 locked is_out", is_out, 0);
    chan_en = 1'b0; write_mode(2'b00);
    chk("R10 unlocked mode", mode, 0); chk("R9 is_out", is_out, 1);

    // R3/R8 directed: code 0011, run of 8 at timer rate
    do_reset(4'd3, 2'd0);
    raw = 1'b1; repeat (3) @(negedge clk);
    raw = 1'b0; repeat (2) @(negedge clk);
    chk("R8 short pulse held", filt, 0);
    raw = 1'b1; repeat (7) @(negedge clk);
    chk("R3 before run end", filt, 0);
    @(negedge clk); chk("R3 run end", filt, 1);

    // swept configurations with random hold lengths
    for (int ci = 0; ci < 11; ci++) begin
      for (int d = 0; d < 4; d++) begin
        logic [3:0] c;
        int p, hold;
        c = (ci == 10) ? 4'd15 : 4'(ci);
        do_reset(c, 2'(d));
        p = period(c, 2'(d));
        write_mode(2'b01);
        hold = 0;
        for (int n = 0; n < 620; n++) begin
          if (hold == 0) begin
            raw = ~raw;
            hold = 1 + int'($urandom_range(0, (run_len(c) + 2) * p));
          end
          hold--;
          @(negedge clk);
          chk(req_of(c), filt, m_filt);
          chk("R9 own follow", cap, m_filt);
        end
      end
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule